// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits inside an SDR SDRAM controller and takes the memory into and out of its self-refresh low-power state when the host side of the controller asks for it. For entry, it closes every open bank with an all-bank precharge. It waits out the row-precharge time and then issues an auto-refresh command in the same cycle that it drops clock-enable. The memory then stays in self-refresh, with clock-enable low, for as long as the request is held; there is no upper bound. When the request is withdrawn, the block raises clock-enable and issues only no-operation commands for the exit recovery time. It then returns control to the host.

The host uses a level handshake. It raises `sr_req` to ask for self-refresh and waits for `sr_ack` to go high, which happens only once the device is fully in self-refresh. It lowers `sr_req` to leave, and may drive commands again only after `sr_ack` falls, which happens once the exit recovery time has elapsed. While the memory is out of self-refresh, the host reports every auto-refresh it issues on `host_ref`. From these pulses the block decides whether a new entry is legal. Re-entry is allowed immediately after a full refresh pass over all rows. Before that, it is allowed only if the previous stay lasted long enough and no refresh window since the exit went short of two refreshes. Timing values are given in nanoseconds together with the clock frequency, and are rounded up to whole cycles.

The state machine has six states. IDLE moves to PRECH on request when re-entry is legal. PRECH always moves to WAIT_RP. WAIT_RP moves to ENTER when the precharge timer expires. ENTER always moves to SELF. SELF moves to EXIT when the request drops. EXIT moves to IDLE when the recovery timer expires.

Top module: `sref_seq`

## Requirements
- R1: Command encoding on `mem_cmd` is {ras_n,cas_n,we_n}: NOP = 3'b111, PRECHARGE = 3'b010, AUTO REFRESH = 3'b001. An accepted request produces a PRECHARGE with `mem_a10` = 1 on the cycle after `sr_req` is sampled high.
- R2: The AUTO REFRESH that enters self-refresh appears exactly TRP_CYC cycles after the PRECHARGE. TRP_CYC is TRP_NS·CLK_MHZ/1000 rounded up, with a minimum of 2.
- R3: The entering AUTO REFRESH is driven with `mem_cke` = 0. For the whole stay, with no time limit, `mem_cke` stays 0 and the command is NOP. `sr_ack` rises on the cycle after the AUTO REFRESH.
- R4: One cycle after `sr_req` is sampled low in self-refresh, `mem_cke` returns to 1. Only NOPs follow. `sr_ack` falls TXSR_CYC cycles after `mem_cke` rises, where TXSR_CYC is TXSR_NS·CLK_MHZ/1000 rounded up, with a minimum of 2.
- R5: After reset, `mem_cke` = 1, `mem_cmd` = NOP, `mem_a10` = 0 and `sr_ack` = 0.
- R6: When re-entry is blocked, a held request produces no PRECHARGE. The PRECHARGE appears two cycles after the cycle carrying the ROWS-th `host_ref` pulse since the last exit.
- R7: Early re-entry is accepted when the last stay had `mem_cke` low for at least DWELL_CYC cycles, and every complete WIN_CYC-cycle window since the exit held at least two `host_ref` pulses. Windows are aligned to the exit, and a window not yet complete imposes nothing.
- R8: A stay shorter than DWELL_CYC cycles blocks early re-entry, whatever the refresh rate afterwards.
- R9: A complete window with fewer than two `host_ref` pulses blocks early re-entry until the full row pass of R6 completes.
- R10: The first request after reset is accepted without any prior refresh activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Host level request to be in self-refresh |
| host_ref | input | 1 | One-cycle pulse per auto-refresh issued by the host while out of self-refresh |
| sr_ack | output | 1 | High while the device is in self-refresh or recovering from it |
| mem_cke | output | 1 | Clock-enable toward the SDRAM |
| mem_cmd | output | 3 | Command {ras_n,cas_n,we_n} toward the SDRAM |
| mem_a10 | output | 1 | Address bit 10 toward the SDRAM (all-bank select on precharge) |

## Verification
A state register stuck in the wrong place shows at the ports within one cycle: a command, a clock-enable level or an acknowledge that does not match the expected point in the sequence. A miscounting timer moves the entering refresh or the acknowledge fall by a cycle, so the bench measures these gaps exactly. A corrupted dwell, window or row tracker only shows at the next request, as a precharge that comes too early or never comes. The bench therefore follows each exit with a request whose legality it predicts from its own account of dwell and refresh spacing.

// File: rtl/sref_pkg.sv
package sref_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_PRE = 3'b010,
        CMD_REF = 3'b001
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_WAIT_RP,
        ST_ENTER,
        ST_SELF,
        ST_EXIT
    } sr_state_e;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns_to_cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int at_least(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/sref_timer.sv
module sref_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sref_guard.sv
module sref_guard #(
    parameter int DWELL_CYC = 6400,
    parameter int WIN_CYC   = 1560,
    parameter int ROWS      = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sr,
    input  logic sr_exit,
    input  logic host_ref,
    output logic reentry_ok
);

    localparam int DW = $clog2(DWELL_CYC + 1);
    localparam int WW = $clog2(WIN_CYC + 1);
    localparam int RW = $clog2(ROWS + 1);

    logic [DW-1:0] dwell_cnt;
    logic          dwell_ok;
    logic [WW-1:0] win_cnt;
    logic [1:0]    win_refs;
    logic          win_fail;
    logic [RW-1:0] rows_cnt;
    logic          rows_done;

    // cycles spent with clock-enable low in the current stay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_cnt <= '0;
            dwell_ok  <= 1'b0;
        end else begin
            if (!in_sr)
                dwell_cnt <= '0;
            else if (int'(dwell_cnt) < DWELL_CYC)
                dwell_cnt <= dwell_cnt + 1'b1;
            if (sr_exit)
                dwell_ok <= (int'(dwell_cnt) + 1 >= DWELL_CYC);
        end
    end

    // fixed refresh windows aligned to the exit, plus the row pass count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            win_refs <= '0;
            win_fail <= 1'b0;
            rows_cnt <= RW'(ROWS);
        end else if (sr_exit) begin
            win_cnt  <= '0;
            win_refs <= '0;
            win_fail <= 1'b0;
            rows_cnt <= '0;
        end else if (!in_sr) begin
            if (host_ref && !rows_done)
                rows_cnt <= rows_cnt + 1'b1;
            if (int'(win_cnt) == WIN_CYC - 1) begin
                win_cnt  <= '0;
                win_refs <= '0;
                if (int'(win_refs) + int'(host_ref) < 2)
                    win_fail <= 1'b1;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (host_ref && win_refs != 2'd2)
                    win_refs <= win_refs + 1'b1;
            end
        end
    end

    assign rows_done  = (int'(rows_cnt) == ROWS);
    assign reentry_ok = rows_done || (dwell_ok && !win_fail);

    AST_ROWS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rows_cnt) <= ROWS); // R6

    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |=> (!win_fail && !rows_done)); // R9

endmodule

// File: rtl/sref_seq.sv
module sref_seq
    import sref_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int TRP_NS   = 20,
    parameter int TXSR_NS  = 70,
    parameter int DWELL_NS = 64000,
    parameter int WIN_NS   = 15600,
    parameter int ROWS     = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_req,
    input  logic       host_ref,
    output logic       sr_ack,
    output logic       mem_cke,
    output logic [2:0] mem_cmd,
    output logic       mem_a10
);

    localparam int TRP_CYC   = at_least(ns_to_cyc(TRP_NS, CLK_MHZ), 2);
    localparam int TXSR_CYC  = at_least(ns_to_cyc(TXSR_NS, CLK_MHZ), 2);
    localparam int DWELL_CYC = at_least(ns_to_cyc(DWELL_NS, CLK_MHZ), 1);
    localparam int WIN_CYC   = at_least(ns_to_cyc(WIN_NS, CLK_MHZ), 1);
    localparam int TRP_WAIT  = TRP_CYC - 2;
    localparam int TXSR_WAIT = TXSR_CYC - 1;
    localparam int TMAX      = (TRP_WAIT > TXSR_WAIT) ? TRP_WAIT : TXSR_WAIT;
    localparam int TW        = $clog2(TMAX + 1) + 1;

    sr_state_e st, st_nx;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          reentry_ok;
    logic          in_sr;
    logic          sr_exit;
    sdr_cmd_e      cmd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // next state and timer loads
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE:    if (sr_req && reentry_ok) st_nx = ST_PRECH;
            ST_PRECH: begin
                st_nx    = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = TW'(TRP_WAIT);
            end
            ST_WAIT_RP: if (tmr_zero) st_nx = ST_ENTER;
            ST_ENTER:   st_nx = ST_SELF;
            ST_SELF: begin
                if (!sr_req) begin
                    st_nx    = ST_EXIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TXSR_WAIT);
                end
            end
            ST_EXIT:    if (tmr_zero) st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        cmd     = CMD_NOP;
        mem_cke = 1'b1;
        mem_a10 = 1'b0;
        sr_ack  = 1'b0;
        unique case (st)
            ST_IDLE:    ;
            ST_PRECH: begin
                cmd     = CMD_PRE;
                mem_a10 = 1'b1;
            end
            ST_WAIT_RP: ;
            ST_ENTER: begin
                cmd     = CMD_REF;
                mem_cke = 1'b0;
            end
            ST_SELF: begin
                mem_cke = 1'b0;
                sr_ack  = 1'b1;
            end
            ST_EXIT:    sr_ack = 1'b1;
            default:    ;
        endcase
    end

    assign mem_cmd = cmd;
    assign in_sr   = (st == ST_ENTER) || (st == ST_SELF);
    assign sr_exit = (st == ST_SELF) && !sr_req;

    sref_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sref_guard #(
        .DWELL_CYC (DWELL_CYC),
        .WIN_CYC   (WIN_CYC),
        .ROWS      (ROWS)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_sr      (in_sr),
        .sr_exit    (sr_exit),
        .host_ref   (host_ref),
        .reentry_ok (reentry_ok)
    );

    // port-level spacing monitors
    localparam int GW = $clog2(TRP_CYC + 1) + 1;
    localparam int XW = $clog2(TXSR_CYC + 1) + 1;
    logic [GW-1:0] pre_gap;
    logic [XW-1:0] cke_up;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_gap <= GW'(TRP_CYC);
            cke_up  <= XW'(TXSR_CYC);
        end else begin
            if (mem_cmd == CMD_PRE)
                pre_gap <= GW'(1);
            else if (int'(pre_gap) < TRP_CYC)
                pre_gap <= pre_gap + 1'b1;
            if (!mem_cke)
                cke_up <= '0;
            else if (int'(cke_up) < TXSR_CYC)
                cke_up <= cke_up + 1'b1;
        end
    end

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == CMD_PRE) |-> mem_a10); // R1

    AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == CMD_REF && !mem_cke) |-> (int'(pre_gap) >= TRP_CYC)); // R2

    AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cke && $past(!mem_cke)) |-> (mem_cmd == CMD_NOP)); // R3

    AST_XSR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cke && int'(cke_up) < TXSR_CYC) |-> (mem_cmd != CMD_PRE && mem_cmd != CMD_REF)); // R4

    AST_ACK_AFTER_XSR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ack) |-> (int'(cke_up) >= TXSR_CYC)); // R4

    AST_ENTRY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == CMD_PRE) |-> $past(reentry_ok)); // R6

endmodule

// File: tb/tb_sref_seq.sv
module tb_sref_seq;

    localparam int PERIOD   = 10;
    localparam int CLK_MHZ  = 100;
    localparam int TRP_NS   = 25;
    localparam int TXSR_NS  = 65;
    localparam int DWELL_NS = 640;
    localparam int WIN_NS   = 300;
    localparam int ROWS     = 16;

    localparam logic [2:0] NOP = 3'b111;
    localparam logic [2:0] PRE = 3'b010;
    localparam logic [2:0] REF = 3'b001;

    function automatic int cyc_up(input int ns);
        int c;
        c = (ns * CLK_MHZ + 999) / 1000;
        return (c < 2) ? 2 : c;
    endfunction

    localparam int EXP_TRP  = cyc_up(TRP_NS);
    localparam int EXP_TXSR = cyc_up(TXSR_NS);
    localparam int EXP_WIN  = cyc_up(WIN_NS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0;
    logic host_ref = 1'b0;
    logic sr_ack, mem_cke, mem_a10;
    logic [2:0] mem_cmd;

    int checks = 0;
    int fails = 0;
    int refs_out = 0;

    always #(PERIOD/2) clk = ~clk;

    sref_seq #(
        .CLK_MHZ (CLK_MHZ), .TRP_NS (TRP_NS), .TXSR_NS (TXSR_NS),
        .DWELL_NS (DWELL_NS), .WIN_NS (WIN_NS), .ROWS (ROWS)
    ) dut (
        .clk (clk), .rst_n (rst_n), .sr_req (sr_req), .host_ref (host_ref),
        .sr_ack (sr_ack), .mem_cke (mem_cke), .mem_cmd (mem_cmd), .mem_a10 (mem_a10)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected legality of the next entry
    function automatic bit exp_allowed(input bit long_stay, input int spacing,
                                       input int outlen, input int refs);
        if (refs >= ROWS) return 1'b1;
        if (!long_stay) return 1'b0;
        return (spacing != 0) || (outlen + EXP_TXSR < EXP_WIN);
    endfunction

    task automatic run_entry();
        int n = 0;
        while (mem_cmd != REF && n < 40) begin
            tick();
            n++;
        end
        chk(n == EXP_TRP, "R2 precharge-to-refresh gap", n, EXP_TRP);
        chk(mem_cke == 1'b0, "R3 cke low on entering refresh", mem_cke, 0);
        tick();
        chk(sr_ack && !mem_cke, "R3 ack after entry", sr_ack, 1);
    endtask

    task automatic enter(input bit allowed, input string tag);
        sr_req = 1'b1;
        tick();
        if (allowed) begin
            chk(mem_cmd == PRE && mem_a10, {tag, " R1 precharge-all"}, mem_cmd, PRE);
        end else begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                if (mem_cmd == PRE) seen++;
                tick();
            end
            chk(seen == 0 && mem_cmd != PRE, {tag, " R6 entry held off"}, seen, 0);
            while (refs_out < ROWS) begin
                host_ref = 1'b1;
                tick();
                host_ref = 1'b0;
                refs_out++;
                if (mem_cmd == PRE) seen++;
                if (refs_out < ROWS) tick();
            end
            tick();
            chk(seen == 0 && mem_cmd == PRE && mem_a10, {tag, " R6 release after row pass"}, mem_cmd, PRE);
        end
        run_entry();
    endtask

    task automatic hold(input int k);
        int bad = 0;
        for (int i = 0; i < k; i++) begin
            tick();
            if (mem_cke || mem_cmd != NOP || !sr_ack) bad++;
        end
        chk(bad == 0, "R3 stay held", bad, 0);
    endtask

    task automatic leave();
        int n = 0;
        int bad = 0;
        sr_req = 1'b0;
        tick();
        chk(mem_cke == 1'b1 && mem_cmd == NOP, "R4 cke up with NOP", mem_cke, 1);
        n = 1;
        while (sr_ack && n < 40) begin
            if (mem_cmd != NOP || !mem_cke) bad++;
            tick();
            n++;
        end
        chk(bad == 0 && n == EXP_TXSR + 1, "R4 recovery length", n - 1, EXP_TXSR);
        refs_out = 0;
    endtask

    task automatic out_period(input int len, input int spacing);
        for (int i = 0; i < len; i++) begin
            host_ref = (spacing != 0) && (i % spacing == 0);
            if (host_ref) refs_out++;
            tick();
        end
        host_ref = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(mem_cke && mem_cmd == NOP && !mem_a10 && !sr_ack, "R5 reset state", mem_cmd, NOP);

        // R10 first entry legal; R3 long stay with no limit
        enter(1'b1, "R10");
        hold(2000);
        leave();

        // R7 long stay then steady refreshes
        enter(1'b1, "R7 after vacuous windows");
        hold(100);
        leave();
        out_period(70, 10);
        enter(1'b1, "R7 dense refresh");

        // R8 short stay blocks early re-entry
        hold(5);
        leave();
        out_period(70, 10);
        enter(1'b0, "R8");

        // R9 starved window blocks early re-entry
        hold(100);
        leave();
        out_period(70, 0);
        enter(1'b0, "R9");

        // R7 immediate request after a long stay
        hold(100);
        leave();
        enter(1'b1, "R7 immediate");

        // randomized stays and out periods
        for (int it = 0; it < 10; it++) begin
            bit lng = $urandom_range(1, 0) == 1;
            int k = lng ? $urandom_range(120, 80) : $urandom_range(8, 3);
            int sp_pick = $urandom_range(3, 0);
            int sp = (sp_pick == 0) ? 0 : 7 + sp_pick;
            int len = $urandom_range(90, 40);
            hold(k);
            leave();
            out_period(len, sp);
            enter(exp_allowed(lng, sp, len, refs_out), "R7/R8/R9 random");
        end

        hold(3);
        leave();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule